// File: doc/BRIEF.md
# Hash Step Function Unit (32-bit sigma and permutation)

This unit evaluates the scalar step functions used by two 32-bit hash algorithms: the four SHA-256 mixing functions (the two small sigmas and the two big sums) and the two SM3 permutations P0 and P1. A processor's execute stage presents one source operand together with an operation code and a valid strobe. One clock later the unit returns the result with its own valid strobe.

Only the low 32 bits of the source operand are used. The six functions share one datapath. That datapath builds three transformed copies of the word, each a right rotation or a logical right shift by an amount chosen from the operation code, and XORs the three copies together. Left rotations are expressed as right rotations by the complementary amount, so that one form of term serves all six functions. The 32-bit result is sign-extended to the register width, which is either 32 or 64 bits and is set by a parameter.

Top module: `hash_sigma_unit`

## Requirements
- R1: Operation code 0 returns (w ror 7) ^ (w ror 18) ^ (w >> 3), where w is the low 32 bits of the source.
- R2: Operation code 1 returns (w ror 17) ^ (w ror 19) ^ (w >> 10).
- R3: Operation code 2 returns (w ror 2) ^ (w ror 13) ^ (w ror 22).
- R4: Operation code 3 returns (w ror 6) ^ (w ror 11) ^ (w ror 25).
- R5: Operation code 4 returns w ^ (w rol 9) ^ (w rol 17).
- R6: Operation code 5 returns w ^ (w rol 15) ^ (w rol 23).
- R7: Source bits above bit 31 have no effect on the result.
- R8: Bits XLEN-1 down to 32 of the result are all equal to bit 31 of the 32-bit result.
- R9: Operation codes 6 and 7 give a result of zero, and out_illegal is high in the same cycle as out_valid.
- R10: out_valid is high exactly one clock after a cycle in which in_valid is high, and low one clock after a cycle in which in_valid is low.
- R11: A synchronous active-high reset clears out_valid and out_illegal.
- R12: out_illegal is never high while out_valid is low, and it is low for operation codes 0 to 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The operation and the source are valid this cycle |
| in_op | input | 3 | Function select: 0 sig0, 1 sig1, 2 sum0, 3 sum1, 4 P0, 5 P1, 6 and 7 reserved |
| in_src | input | XLEN | Source operand; only bits 31:0 are used |
| out_valid | output | 1 | Result is valid; one cycle after in_valid |
| out_result | output | XLEN | Sign-extended 32-bit result |
| out_illegal | output | 1 | A reserved operation code was issued |

## Verification
The assertions assume that in_op and in_src carry known values in every cycle where in_valid is high, and that reset is applied before the first request. The bench changes its inputs only on falling edges and holds them stable through the following rising edge. It drives all eight operation codes, including both reserved ones, and runs the 64-bit configuration so that the sign-extension and upper-bit checks exercise real bits.

// File: rtl/hsu_pkg.sv
`timescale 1ns/1ps
package hsu_pkg;
    localparam int WORD_W  = 32;
    localparam int AMT_W   = $clog2(WORD_W);
    localparam int N_TERMS = 3;

    typedef enum logic [2:0] {
        OP_SIG0 = 3'd0,
        OP_SIG1 = 3'd1,
        OP_SUM0 = 3'd2,
        OP_SUM1 = 3'd3,
        OP_P0   = 3'd4,
        OP_P1   = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } hsu_op_e;

    // One term: right rotate by amt, or logical right shift when shift_only
    typedef struct packed {
        logic [AMT_W-1:0] amt;
        logic             shift_only;
    } term_cfg_t;

    typedef struct packed {
        term_cfg_t [N_TERMS-1:0] term;
        logic                    illegal;
    } op_cfg_t;

    function automatic term_cfg_t ror_term(input int n);
        term_cfg_t t;
        t.amt        = AMT_W'(n);
        t.shift_only = 1'b0;
        return t;
    endfunction

    function automatic term_cfg_t shr_term(input int n);
        term_cfg_t t;
        t.amt        = AMT_W'(n);
        t.shift_only = 1'b1;
        return t;
    endfunction

    // Left rotation by n expressed as right rotation
    function automatic term_cfg_t rol_term(input int n);
        return ror_term((WORD_W - n) % WORD_W);
    endfunction
endpackage

// File: rtl/hsu_decode.sv
`timescale 1ns/1ps
module hsu_decode
    import hsu_pkg::*;
(
    input  logic [2:0] op,
    output op_cfg_t    cfg
);
    always_comb begin
        cfg = '0;
        unique case (hsu_op_e'(op))
            OP_SIG0: begin
                cfg.term[0] = ror_term(7);
                cfg.term[1] = ror_term(18);
                cfg.term[2] = shr_term(3);
            end
            OP_SIG1: begin
                cfg.term[0] = ror_term(17);
                cfg.term[1] = ror_term(19);
                cfg.term[2] = shr_term(10);
            end
            OP_SUM0: begin
                cfg.term[0] = ror_term(2);
                cfg.term[1] = ror_term(13);
                cfg.term[2] = ror_term(22);
            end
            OP_SUM1: begin
                cfg.term[0] = ror_term(6);
                cfg.term[1] = ror_term(11);
                cfg.term[2] = ror_term(25);
            end
            OP_P0: begin
                cfg.term[0] = ror_term(0);
                cfg.term[1] = rol_term(9);
                cfg.term[2] = rol_term(17);
            end
            OP_P1: begin
                cfg.term[0] = ror_term(0);
                cfg.term[1] = rol_term(15);
                cfg.term[2] = rol_term(23);
            end
            default: cfg.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/hsu_term.sv
`timescale 1ns/1ps
module hsu_term
    import hsu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] word,
    input  term_cfg_t    cfg,
    output logic [W-1:0] y
);
    logic [2*W-1:0] doubled;
    logic [2*W-1:0] spun;
    logic [W-1:0]   shifted;

    always_comb begin
        doubled = {word, word};
        spun    = doubled >> cfg.amt;
        shifted = word >> cfg.amt;
        y       = cfg.shift_only ? shifted : spun[W-1:0];
    end
endmodule

// File: rtl/hsu_mix.sv
`timescale 1ns/1ps
module hsu_mix #(
    parameter int W = 32,
    parameter int N = 3
) (
    input  logic [N*W-1:0] terms,
    output logic [W-1:0]   y
);
    logic [W-1:0] acc [N+1];

    assign acc[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_fold
        assign acc[i+1] = acc[i] ^ terms[i*W +: W];
    end
    assign y = acc[N];
endmodule

// File: rtl/hash_sigma_unit.sv
`timescale 1ns/1ps
module hash_sigma_unit
    import hsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [2:0]      in_op,
    input  logic [XLEN-1:0] in_src,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic            out_illegal
);
    localparam int EXT_W = XLEN - WORD_W;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [XLEN-1:0] result;
    } state_t;

    state_t st_d, st_q;

    op_cfg_t             cfg;
    logic [WORD_W-1:0]   word;
    logic [N_TERMS*WORD_W-1:0] terms;
    logic [WORD_W-1:0]   mixed;
    logic [WORD_W-1:0]   res32;
    logic [XLEN-1:0]     res_ext;

    assign word = in_src[WORD_W-1:0];

    hsu_decode u_dec (
        .op  (in_op),
        .cfg (cfg)
    );

    for (genvar i = 0; i < N_TERMS; i++) begin : g_term
        hsu_term #(.W(WORD_W)) u_term (
            .word (word),
            .cfg  (cfg.term[i]),
            .y    (terms[i*WORD_W +: WORD_W])
        );
    end

    hsu_mix #(.W(WORD_W), .N(N_TERMS)) u_mix (
        .terms (terms),
        .y     (mixed)
    );

    assign res32 = cfg.illegal ? '0 : mixed;

    if (EXT_W > 0) begin : g_wide
        logic unused_upper;
        assign unused_upper = ^in_src[XLEN-1:WORD_W];
        assign res_ext = {{EXT_W{res32[WORD_W-1]}}, res32};
    end else begin : g_narrow
        assign res_ext = res32;
    end

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.illegal = in_valid & cfg.illegal;
        if (in_valid) begin
            st_d.result = res_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign out_result  = st_q.result;
endmodule

// File: rtl/hsu_chk.sv
`timescale 1ns/1ps
module hsu_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [2:0]      in_op,
    input logic [XLEN-1:0] in_src,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic            out_illegal
);
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R10
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9
    reserved_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2] && in_op[1]) |=> (out_illegal && out_result == '0));
    // R12
    legal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(in_op[2] && in_op[1])) |=> !out_illegal);
    // R12
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_valid);
    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal));
    // R7
    src_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $past(in_valid) && $stable(in_op) && $stable(in_src[31:0]))
        |=> $stable(out_result));

    if (XLEN > 32) begin : g_ext
        // R8
        sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}}));
    end
endmodule

bind hash_sigma_unit hsu_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_src      (in_src),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/sim_hash_sigma_unit.sv
`timescale 1ns/1ps
module sim_hash_sigma_unit;
    localparam int XW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = '0;
    logic [XW-1:0] in_src = '0;
    logic          out_valid;
    logic [XW-1:0] out_result;
    logic          out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    hash_sigma_unit #(.XLEN(XW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_src(in_src), .out_valid(out_valid), .out_result(out_result),
        .out_illegal(out_illegal)
    );

    function automatic logic [31:0] rr(input logic [31:0] w, input int n);
        return (n == 0) ? w : ((w >> n) | (w << (32 - n)));
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] w, input int n);
        return (n == 0) ? w : ((w << n) | (w >> (32 - n)));
    endfunction

    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] w);
        case (op)
            3'd0: return rr(w, 7) ^ rr(w, 18) ^ (w >> 3);
            3'd1: return rr(w, 17) ^ rr(w, 19) ^ (w >> 10);
            3'd2: return rr(w, 2) ^ rr(w, 13) ^ rr(w, 22);
            3'd3: return rr(w, 6) ^ rr(w, 11) ^ rr(w, 25);
            3'd4: return w ^ rl(w, 9) ^ rl(w, 17);
            3'd5: return w ^ rl(w, 15) ^ rl(w, 23);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [XW-1:0] sext(input logic [31:0] v);
        return {{(XW-32){v[31]}}, v};
    endfunction

    task automatic chk(input string req, input logic [XW-1:0] act, input logic [XW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request at a falling edge, sample one clock later
    task automatic issue(input string req, input logic [2:0] op, input logic [XW-1:0] src);
        logic illegal_exp;
        illegal_exp = op[2] & op[1];
        in_valid = 1'b1;
        in_op    = op;
        in_src   = src;
        @(negedge clk);
        chk(req, {63'b0, out_valid}, 64'd1);
        chk(req, out_result, sext(model(op, src[31:0])));
        chk({req, " R12"}, {63'b0, out_illegal}, {63'b0, illegal_exp});
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 valid", {63'b0, out_valid}, 64'd0);
        chk("R11 illegal", {63'b0, out_illegal}, 64'd0);
    endtask

    task automatic t_function(input logic [2:0] op, input string req);
        issue(req, op, 64'h0);
        issue(req, op, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(req, op, 64'h0000_0000_8000_0000);
        for (int i = 0; i < 25; i++) begin
            issue(req, op, {$urandom(), $urandom()});
        end
    endtask

    task automatic t_upper_ignored;  // R7
        logic [31:0] w;
        for (int op = 0; op < 6; op++) begin
            w = $urandom();
            issue("R7", 3'(op), {32'h0, w});
            issue("R7", 3'(op), {32'hDEAD_BEEF, w});
            issue("R7", 3'(op), {32'hFFFF_FFFF, w});
        end
    endtask

    task automatic t_sign;  // R8: result with bit 31 set and clear
        @(negedge clk);
        issue("R8", 3'd4, 64'h0000_0000_8000_0000);
        chk("R8 upper ones", {32'h0, out_result[63:32]}, 64'hFFFF_FFFF);
        issue("R8", 3'd2, 64'h0);
        chk("R8 upper zeros", {32'h0, out_result[63:32]}, 64'h0);
    endtask

    task automatic t_reserved;  // R9
        issue("R9", 3'd6, 64'h1234_5678_9ABC_DEF0);
        chk("R9 zero", out_result, 64'h0);
        chk("R9 flag", {63'b0, out_illegal}, 64'd1);
        issue("R9", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R9 zero", out_result, 64'h0);
        chk("R9 flag", {63'b0, out_illegal}, 64'd1);
    endtask

    task automatic t_latency;  // R10
        @(negedge clk);
        chk("R10 idle", {63'b0, out_valid}, 64'd0);
        in_valid = 1'b1; in_op = 3'd1; in_src = 64'h0F0F_0F0F;
        @(posedge clk); #1;
        chk("R10 after one edge", {63'b0, out_valid}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10 drops", {63'b0, out_valid}, 64'd0);
        chk("R12 no flag when idle", {63'b0, out_illegal}, 64'd0);
    endtask

    task automatic t_reset_mid;  // R11
        in_valid = 1'b1; in_op = 3'd7; in_src = 64'h5;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 mid valid", {63'b0, out_valid}, 64'd0);
        chk("R11 mid illegal", {63'b0, out_illegal}, 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_function(3'd0, "R1");
        t_function(3'd1, "R2");
        t_function(3'd2, "R3");
        t_function(3'd3, "R4");
        t_function(3'd4, "R5");
        t_function(3'd5, "R6");
        t_upper_ignored();
        t_sign();
        t_reserved();
        t_latency();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule